// File: doc/BRIEF.md
# Codec control register bank

This block holds the control and status words of an audio converter behind a plain parallel host port. A 4-bit address picks one of sixteen 10-bit locations. A write strobe stores the write data. A read strobe returns the addressed word on the read data output one clock later. Most locations are read/write: converter setup, per-channel volumes and a reserved slot. Each of these comes out of reset with a fixed value.

Two locations are read-only peak-level holders, one per input channel. An upstream level estimator delivers ready-made 6-bit level codes, each with a valid strobe and a channel select. While peak capture is enabled, each holder keeps the largest code seen on its channel. A holder clears itself when the host reads it, so each read covers only the activity since the read before.

Top module: `codec_ctl_bank`

## Requirements
- R1: After reset, addresses 0x2 to 0x9 read 0x3FF, and every other address reads 0x000. This includes the two peak addresses 0xA and 0xB.
- R2: A write to any address other than 0xA and 0xB stores the 10-bit write data. This includes the reserved address 0xF. A later read returns that data.
- R3: Writes to 0xA and 0xB have no effect on what those addresses read back.
- R4: A read of 0xA or 0xB returns the 6-bit peak code in bits 9:4. Bits 3:0 of that read are zero.
- R5: Level codes on channel 0 feed the holder at 0xA, and codes on channel 1 feed the holder at 0xB. A holder takes a valid code only when the code is strictly greater than the value it holds.
- R6: Peak capture is enabled by bit 0 of address 0xE. While that bit is 0, both holders keep their value and ignore level codes.
- R7: Reading a peak address clears that holder to zero, so the next read returns only codes captured after the previous read.
- R8: A level code for a channel can arrive in the same cycle as a read of that channel's peak address, with capture enabled. The read returns the previous peak, and the holder then holds the new code instead of zero.
- R9: Read data appears one clock after the read strobe and keeps its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address for reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 10 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 10 | Registered read data |
| lvl_valid_i | input | 1 | Level code valid |
| lvl_ch_i | input | 1 | Channel of the level code |
| lvl_code_i | input | 6 | Level code, 0 to 63 |

## Verification
The bench builds the bank with its default parameters: a 4-bit address, 10-bit words, 6-bit level codes and two channels. At that size every address can be swept for its reset value, for write-back and for read-only behaviour. Every one of the 64 level codes is driven on both channels in a scrambled order, with reads interleaved so that the clear-on-read path is exercised. A plain arithmetic model predicts each read. Directed cases cover capture while disabled and a read that coincides with a sample on the same channel and on the other channel.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int unsigned PEAK_BASE = 10;
  localparam int unsigned CTL_EN_ADDR = 14;
  localparam int unsigned CTL_EN_BIT = 0;
  localparam int unsigned VOL_LO = 2;
  localparam int unsigned VOL_HI = 9;

  function automatic bit is_vol(int unsigned idx);
    return (idx >= VOL_LO) && (idx <= VOL_HI);
  endfunction

  function automatic bit is_peak(int unsigned idx, int unsigned n_ch);
    return (idx >= PEAK_BASE) && (idx < PEAK_BASE + n_ch);
  endfunction
endpackage

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import codec_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned N_CH = 2,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  regs_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (is_peak(i, N_CH)) begin : g_ro
      // peak slots live in the holders, nothing stored here
      assign regs_o[i] = '0;
    end else begin : g_rw
      localparam logic [DATA_W-1:0] RST_VAL = is_vol(i) ? {DATA_W{1'b1}} : '0;
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= RST_VAL;
        else if (wr_en_i && addr_i == ADDR_W'(i)) r_q <= wr_data_i;
      end
      assign regs_o[i] = r_q;
    end
  end

  assert_write_stores_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !is_peak(32'(addr_i), N_CH)) |=> regs_o[$past(addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             smp_i,
  input  logic [LVL_W-1:0] code_i,
  input  logic             clr_i,
  output logic [LVL_W-1:0] peak_o
);
  logic [LVL_W-1:0] held_q;
  logic take;

  assign take = en_i && smp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else if (clr_i) held_q <= take ? code_i : '0;
    else if (take && code_i > held_q) held_q <= code_i;
  end

  assign peak_o = held_q;

  assert_hold_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(peak_o));
  assert_never_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> peak_o >= $past(peak_o));
  assert_clear_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !take) |=> peak_o == '0);
  assert_collide_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && take) |=> peak_o == $past(code_i));
endmodule

// File: rtl/codec_ctl_bank.sv
module codec_ctl_bank
  import codec_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned LVL_W = 6,
  parameter int unsigned N_CH = 2,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              lvl_valid_i,
  input  logic [CH_W-1:0]   lvl_ch_i,
  input  logic [LVL_W-1:0]  lvl_code_i
);
  logic [DEPTH-1:0][DATA_W-1:0] regs;
  logic [N_CH-1:0][LVL_W-1:0]   peak;
  logic [N_CH-1:0]              clr;
  logic                         cap_en;
  logic [DATA_W-1:0]            rd_next;
  logic [DATA_W-1:0]            rd_q;

  ctl_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i, .regs_o(regs)
  );

  assign cap_en = regs[CTL_EN_ADDR][CTL_EN_BIT];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign clr[c] = rd_en_i && addr_i == ADDR_W'(PEAK_BASE + c);
    peak_hold #(.LVL_W(LVL_W)) u_peak (
      .clk_i, .rst_ni,
      .en_i  (cap_en),
      .smp_i (lvl_valid_i && lvl_ch_i == CH_W'(c)),
      .code_i(lvl_code_i),
      .clr_i (clr[c]),
      .peak_o(peak[c])
    );

    assert_ro_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(PEAK_BASE + c) && !lvl_valid_i && !rd_en_i)
      |=> $stable(peak[c]));
  end

  always_comb begin
    rd_next = regs[addr_i];
    for (int c = 0; c < N_CH; c++)
      if (clr[c]) rd_next = {peak[c], {(DATA_W-LVL_W){1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_next;
  end

  assign rd_data_o = rd_q;

  assert_peak_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr) |=> rd_data_o[DATA_W-LVL_W-1:0] == '0);
  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  assert_single_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));
endmodule

// File: tb/sim_codec_ctl_bank.sv
module sim_codec_ctl_bank;
  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0;
  logic wr_en = 0, rd_en = 0, lvl_valid = 0, lvl_ch = 0;
  logic [9:0] wr_data = 0, rd_data;
  logic [5:0] lvl_code = 0;
  int n_tests = 0, n_fail = 0;
  logic [9:0] m_reg [16];
  logic [5:0] m_peak [2];
  logic m_en = 0;

  always #2 clk = ~clk;

  codec_ctl_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .lvl_valid_i(lvl_valid), .lvl_ch_i(lvl_ch),
    .lvl_code_i(lvl_code)
  );

  task automatic check(string req, logic [9:0] got, logic [9:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [9:0] m_read(int a);
    if (a == 10 || a == 11) return {m_peak[a-10], 4'b0};
    return m_reg[a];
  endfunction

  task automatic wr(int a, logic [9:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a != 10 && a != 11) m_reg[a] = d;
    if (a == 14) m_en = d[0];
  endtask

  // read with optional same-cycle sample; returns sampled rd_data
  task automatic rd(int a, bit smp, bit ch, logic [5:0] code, output logic [9:0] got,
                    output logic [9:0] exp);
    @(negedge clk); rd_en = 1; addr = 4'(a);
    lvl_valid = smp; lvl_ch = ch; lvl_code = code;
    exp = m_read(a);
    @(negedge clk); rd_en = 0; lvl_valid = 0;
    got = rd_data;
    if (a == 10 || a == 11) m_peak[a-10] = 0;
    if (smp && m_en && (code > m_peak[ch] || (a == 10 + ch))) m_peak[ch] = code;
  endtask

  task automatic lvl(bit ch, logic [5:0] code);
    @(negedge clk); lvl_valid = 1; lvl_ch = ch; lvl_code = code;
    @(negedge clk); lvl_valid = 0;
    if (m_en && code > m_peak[ch]) m_peak[ch] = code;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [9:0] g, e;
    for (int a = 0; a < 16; a++) m_reg[a] = (a >= 2 && a <= 9) ? 10'h3FF : 10'h000;
    m_peak[0] = 0; m_peak[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 16; a++) begin
      rd(a, 0, 0, 0, g, e); check("R1", g, e);
    end
    // R2 / R3 write sweep, then readback; enable stays 0 here
    for (int a = 0; a < 16; a++) wr(a, 10'((a * 97 + 13) & 10'h3FE));
    for (int a = 0; a < 16; a++) begin
      rd(a, 0, 0, 0, g, e);
      check((a == 10 || a == 11) ? "R3" : "R2", g, e);
    end
    // R9 hold between reads
    rd(3, 0, 0, 0, g, e);
    repeat (5) @(negedge clk);
    check("R9", rd_data, e);
    // R6: samples with capture off are ignored
    lvl(0, 6'd40); lvl(1, 6'd50);
    rd(10, 0, 0, 0, g, e); check("R6", g, 10'h000);
    rd(11, 0, 0, 0, g, e); check("R6", g, 10'h000);
    // enable capture; sweep all codes scrambled on both channels
    wr(14, 10'h001);
    for (int k = 0; k < 64; k++) begin
      lvl(0, 6'((k * 29 + 7) % 64));
      lvl(1, 6'((k * 45 + 3) % 64));
      if (k % 8 == 7) begin
        rd(10, 0, 0, 0, g, e); check("R5", g, e); check("R4", {6'b0, g[3:0]}, 10'h0);
        rd(11, 0, 0, 0, g, e); check("R5", g, e);
      end
    end
    // R5 not-greater code leaves value
    lvl(0, 6'd30); lvl(0, 6'd12); lvl(0, 6'd30);
    rd(10, 0, 0, 0, g, e); check("R5", g, {6'd30, 4'b0});
    // R7 second read after clear returns zero
    rd(10, 0, 0, 0, g, e); check("R7", g, 10'h000);
    // R3 write to peak with a held value
    lvl(1, 6'd21);
    wr(11, 10'h3FF);
    rd(11, 0, 0, 0, g, e); check("R3", g, {6'd21, 4'b0});
    // R8 collision on same channel
    lvl(0, 6'd50);
    rd(10, 1, 0, 6'd5, g, e); check("R8", g, {6'd50, 4'b0});
    rd(10, 0, 0, 0, g, e); check("R8", g, {6'd5, 4'b0});
    // read of ch0 with sample on ch1
    lvl(0, 6'd33); lvl(1, 6'd9);
    rd(10, 1, 1, 6'd44, g, e); check("R7", g, {6'd33, 4'b0});
    rd(11, 0, 0, 0, g, e); check("R5", g, {6'd44, 4'b0});
    rd(10, 0, 0, 0, g, e); check("R7", g, 10'h000);
    // R6 disable keeps held value
    lvl(1, 6'd17);
    wr(14, 10'h000);
    lvl(1, 6'd60);
    rd(11, 0, 0, 0, g, e); check("R6", g, {6'd17, 4'b0});
    rd(11, 1, 1, 6'd62, g, e); check("R6", g, 10'h000);
    rd(11, 0, 0, 0, g, e); check("R6", g, 10'h000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule